// File: doc/BRIEF.md
# Flash Bank Erase-Verify Sequencer

This block runs one complete erase of a flash bank without processor help. After a start pulse it writes an erase command into the flash control register. It then watches the busy bit of the status word until the array has finished. Next it checks the programming-voltage fault flag and walks a word pointer from the bank base to the bank limit. Each word gets an erase-verify made of two reads of the same address. The reads are separated by a fixed wait that the clock-frequency parameter turns into cycles, and only the second read is compared against all ones.

A failing word costs one attempt from a counter loaded at start. While attempts remain, the bank is erased again and re-verified from its base. A voltage fault after an erase causes a fresh erase if the supply is now in range, or an abort if it is still bad. Every exit clears the write-enable bit of the control register, which returns the flash to normal reading. The exit also raises a one-cycle done pulse together with a result code.

Top module: `flash_erase_seq`

## Requirements
- R1: A start pulse in idle raises busy and issues an erase command in the next cycle. A start seen while busy is ignored: it neither reloads the attempt counter nor causes a second done.
- R2: The erase command is a control write with bit 0 (write enable) and bit 1 (erase go) set. The flash is not read while status bit 2 (busy) reads 1 after the command.
- R3: When busy clears, status bit 3 (voltage fault) is checked. If it is set and supply_ok is 1, a new erase is issued and no attempt is consumed. If it is set and supply_ok is 0, the routine ends with result 2'b01 and no flash read.
- R4: Each word is read twice at the same address. The second read strobe comes exactly WAIT_CYC = CLK_HZ/250000 cycles after the first. Only the data returned one cycle after the second strobe is compared with all ones, and the first read's data is ignored.
- R5: A verify mismatch decrements the attempt counter by one, which starts at MAX_ATTEMPTS. If attempts remain, the bank is erased again and re-verified from BANK_BASE. A bank that fails on MAX_ATTEMPTS erases ends with result 2'b10.
- R6: A word that passes verify leaves the attempt counter unchanged.
- R7: After a pass, the pointer moves to the next word. A pass at BANK_LIMIT ends the routine with result 2'b00.
- R8: Every exit writes 0 to the control register (write enable cleared) in the same cycle as done. Done lasts exactly one cycle, and result is valid while done is high.
- R9: After reset, busy, done, ctrl_we and rd_en are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an erase pass (idle only) |
| supply_ok | input | 1 | Live indication that the programming voltage is in range |
| ctrl_rdata | input | 16 | Control/status word: bit 2 busy, bit 3 voltage fault |
| rd_data | input | 16 | Flash read data, valid one cycle after rd_en |
| busy | output | 1 | Sequencer active |
| done | output | 1 | One-cycle end-of-routine pulse |
| result | output | 2 | 00 erased, 01 voltage abort, 10 unerasable |
| ctrl_we | output | 1 | Control register write strobe |
| ctrl_wdata | output | 16 | Control register write data |
| rd_en | output | 1 | Flash read strobe |
| rd_addr | output | ADDR_W | Flash word address |

## Verification
The assertions take several properties of the environment for granted. The busy bit must rise on the clock edge that accepts the erase command and stay high until the array is finished. The fault flag must be settled by the time busy drops. Read data must arrive exactly one cycle after its strobe. The bench keeps within these rules with a behavioural flash model: it sets busy on the command edge for a fixed count, latches the fault flag as busy ends, and returns registered data that is deliberately wrong on every first read of a pair.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;

  localparam int CTRL_W     = 16;
  localparam int BIT_WE     = 0;
  localparam int BIT_GO     = 1;
  localparam int BIT_BUSY   = 2;
  localparam int BIT_VFAULT = 3;

  typedef enum logic [3:0] {
    S_IDLE, S_ERASE, S_POLL, S_VCHK, S_READ1,
    S_WAIT, S_READ2, S_CMP, S_EXIT
  } seq_state_e;

  typedef enum logic [1:0] {
    RES_OK         = 2'b00,
    RES_VFAULT     = 2'b01,
    RES_UNERASABLE = 2'b10
  } seq_result_e;

endpackage

// File: rtl/erase_wait_timer.sv
module erase_wait_timer #(
  parameter int WAIT_CYC = 100,
  localparam int CNT_W   = $clog2(WAIT_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic run,
  output logic last
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                  cnt <= '0;
    else if (load)            cnt <= CNT_W'(WAIT_CYC - 1);
    else if (run && cnt != 0) cnt <= cnt - 1'b1;
  end

  assign last = (cnt == CNT_W'(1));

  // R4: a load always starts the window at its full length
  a_r4_timer_load: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt == CNT_W'(WAIT_CYC - 1)));
endmodule

// File: rtl/erase_attempt_ctr.sv
module erase_attempt_ctr #(
  parameter int MAX_ATTEMPTS = 16,
  localparam int CNT_W       = $clog2(MAX_ATTEMPTS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic dec,
  output logic last
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                 cnt <= '0;
    else if (load)           cnt <= CNT_W'(MAX_ATTEMPTS);
    else if (dec && cnt != 0) cnt <= cnt - 1'b1;
  end

  assign last = (cnt == CNT_W'(1));

  // R5: a mismatch costs exactly one attempt
  a_r5_dec_by_one: assert property (@(posedge clk) disable iff (rst)
    (dec && !load && cnt != 0) |=> (cnt == $past(cnt) - 1'b1));
  // R6: without a mismatch or a start the count never moves
  a_r6_hold_on_pass: assert property (@(posedge clk) disable iff (rst)
    (!dec && !load) |=> $stable(cnt));
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import flash_erase_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int BANK_BASE    = 0,
  parameter int BANK_LIMIT   = 255,
  parameter int CLK_HZ       = 25_000_000,
  parameter int MAX_ATTEMPTS = 16,
  localparam int WAIT_CYC    = CLK_HZ / 250_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              supply_ok,
  input  logic [CTRL_W-1:0] ctrl_rdata,
  input  logic [15:0]       rd_data,
  output logic              busy,
  output logic              done,
  output logic [1:0]        result,
  output logic              ctrl_we,
  output logic [CTRL_W-1:0] ctrl_wdata,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr
);
  localparam logic [ADDR_W-1:0] BASE_A  = ADDR_W'(BANK_BASE);
  localparam logic [ADDR_W-1:0] LIMIT_A = ADDR_W'(BANK_LIMIT);

  seq_state_e st, nxt;
  logic [ADDR_W-1:0] ptr;
  seq_result_e res_q;
  logic tmr_last, att_last, word_ok, at_limit, st_busy, st_fault;
  logic unused_stat_bits;

  assign word_ok          = (rd_data == 16'hFFFF);
  assign at_limit         = (ptr == LIMIT_A);
  assign st_busy          = ctrl_rdata[BIT_BUSY];
  assign st_fault         = ctrl_rdata[BIT_VFAULT];
  assign unused_stat_bits = ^ctrl_rdata;

  erase_wait_timer #(.WAIT_CYC(WAIT_CYC)) u_timer (
    .clk(clk), .rst(rst), .load(st == S_READ1), .run(st == S_WAIT), .last(tmr_last)
  );

  erase_attempt_ctr #(.MAX_ATTEMPTS(MAX_ATTEMPTS)) u_attempts (
    .clk(clk), .rst(rst), .load(st == S_IDLE && start),
    .dec(st == S_CMP && !word_ok), .last(att_last)
  );

  always_comb begin
    nxt = st;
    unique case (st)
      S_IDLE:  if (start) nxt = S_ERASE;
      S_ERASE: nxt = S_POLL;
      S_POLL:  if (!st_busy) nxt = S_VCHK;
      S_VCHK:  if (st_fault) nxt = supply_ok ? S_ERASE : S_EXIT;
               else          nxt = S_READ1;
      S_READ1: nxt = S_WAIT;
      S_WAIT:  if (tmr_last) nxt = S_READ2;
      S_READ2: nxt = S_CMP;
      S_CMP:   if (word_ok) nxt = at_limit ? S_EXIT : S_READ1;
               else         nxt = att_last ? S_EXIT : S_ERASE;
      S_EXIT:  nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      ptr        <= BASE_A;
      res_q      <= RES_OK;
      busy       <= 1'b0;
      done       <= 1'b0;
      ctrl_we    <= 1'b0;
      ctrl_wdata <= '0;
      rd_en      <= 1'b0;
    end else begin
      st         <= nxt;
      busy       <= (nxt != S_IDLE);
      done       <= (nxt == S_EXIT);
      ctrl_we    <= (nxt == S_ERASE) || (nxt == S_EXIT);
      ctrl_wdata <= '0;
      if (nxt == S_ERASE) begin
        ctrl_wdata[BIT_WE] <= 1'b1;
        ctrl_wdata[BIT_GO] <= 1'b1;
      end
      rd_en <= (nxt == S_READ1) || (nxt == S_READ2);

      if (st == S_IDLE && start) ptr <= BASE_A;
      if (st == S_CMP) begin
        if (word_ok && !at_limit) ptr <= ptr + 1'b1;
        else if (!word_ok)        ptr <= BASE_A;
      end

      if (st == S_VCHK && st_fault && !supply_ok) res_q <= RES_VFAULT;
      if (st == S_CMP && word_ok && at_limit)     res_q <= RES_OK;
      if (st == S_CMP && !word_ok && att_last)    res_q <= RES_UNERASABLE;
    end
  end

  assign rd_addr = ptr;
  assign result  = res_q;

  // R1: start from idle produces an erase command right away
  a_r1_start_launches: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && start) |=> (busy && ctrl_we && ctrl_wdata[BIT_GO]));
  // R2: no flash read while the array reports busy
  a_r2_hold_while_busy: assert property (@(posedge clk) disable iff (rst)
    (st == S_POLL && st_busy) |=> !rd_en);
  // R4: the second read of a pair uses the same address as the first
  a_r4_same_addr: assert property (@(posedge clk) disable iff (rst)
    (st == S_READ2) |-> (rd_en && $stable(rd_addr)));
  // R8: exit clears write enable together with done
  a_r8_done_clears_we: assert property (@(posedge clk) disable iff (rst)
    done |-> (ctrl_we && !ctrl_wdata[BIT_WE]));
  // R8: done is a single-cycle pulse
  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: tb/test_flash_erase_seq.sv
module test_flash_erase_seq;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 4;
  localparam int BASE       = 2;
  localparam int LIMIT      = 9;
  localparam int CLK_HZ     = 1_000_000;
  localparam int MAXA       = 3;
  localparam int WAITC      = CLK_HZ / 250_000;
  localparam int NW         = LIMIT - BASE + 1;
  localparam int BUSY_CYC   = 5;

  logic clk = 0, rst = 1, start = 0, supply_ok = 1;
  logic [15:0] ctrl_rdata, rd_data, ctrl_wdata;
  logic busy, done, ctrl_we, rd_en;
  logic [1:0] result;
  logic [ADDR_W-1:0] rd_addr;

  flash_erase_seq #(.ADDR_W(ADDR_W), .BANK_BASE(BASE), .BANK_LIMIT(LIMIT),
                    .CLK_HZ(CLK_HZ), .MAX_ATTEMPTS(MAXA)) i_flash_erase_seq (
    .clk(clk), .rst(rst), .start(start), .supply_ok(supply_ok),
    .ctrl_rdata(ctrl_rdata), .rd_data(rd_data), .busy(busy), .done(done),
    .result(result), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .rd_en(rd_en), .rd_addr(rd_addr));

  always #(CLK_PERIOD/2) clk = ~clk;

  // flash and control-register model
  logic env_clear = 1;
  int fail_n = 0, stuck = BASE, fault_on = 0;
  int erase_n, busy_cnt;
  logic env_fault, flt_next, rd_phase;
  logic [15:0] mem [16];
  assign ctrl_rdata = {12'b0, env_fault, (busy_cnt != 0), 2'b00};

  always @(posedge clk) begin
    if (env_clear) begin
      for (int i = 0; i < 16; i++) mem[i] <= 16'h0000;
      erase_n <= 0; busy_cnt <= 0; env_fault <= 0; flt_next <= 0;
      rd_phase <= 0; rd_data <= 16'h0000;
    end else begin
      if (ctrl_we && ctrl_wdata[1]) begin
        erase_n   <= erase_n + 1;
        busy_cnt  <= BUSY_CYC;
        env_fault <= 0;
        flt_next  <= (erase_n + 1 == fault_on);
        for (int i = BASE; i <= LIMIT; i++)
          mem[i] <= (i == stuck && erase_n + 1 <= fail_n) ? 16'h00F0 : 16'hFFFF;
      end else if (busy_cnt > 0) begin
        busy_cnt <= busy_cnt - 1;
        if (busy_cnt == 1) env_fault <= flt_next;
      end
      if (rd_en) begin
        rd_phase <= !rd_phase;
        rd_data  <= rd_phase ? mem[rd_addr] : 16'h1234;
      end
    end
  end

  // monitors
  int cyc = 0, n_reads, n_done, pair_bad, busy_rd_bad, clr_bad, last_cyc;
  logic [ADDR_W-1:0] last_addr;
  logic mon_phase;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (env_clear) begin
      n_reads <= 0; n_done <= 0; pair_bad <= 0; busy_rd_bad <= 0;
      clr_bad <= 0; mon_phase <= 0; last_cyc <= 0; last_addr <= '0;
    end else begin
      if (rd_en) begin
        n_reads   <= n_reads + 1;
        mon_phase <= !mon_phase;
        if (busy_cnt != 0) busy_rd_bad <= busy_rd_bad + 1;
        if (!mon_phase) begin
          last_cyc <= cyc; last_addr <= rd_addr;
        end else if (cyc - last_cyc != WAITC || rd_addr != last_addr)
          pair_bad <= pair_bad + 1;
      end
      if (done) begin
        n_done <= n_done + 1;
        if (!(ctrl_we && ctrl_wdata[0] == 1'b0)) clr_bad <= clr_bad + 1;
      end
    end
  end

  int n_chk = 0, n_fail = 0;
  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_case(input int fn, input int sa, input int fo, input bit sup,
                          input bit extra, input string tag);
    int ws, e_res, e_er, e_rd, w;
    ws = sa - BASE + 1;
    if (fo == 1 && !sup) begin e_res = 1; e_er = 1; e_rd = 0; end
    else begin
      if (fn >= MAXA) begin e_res = 2; e_er = MAXA; e_rd = MAXA * 2 * ws; end
      else begin e_res = 0; e_er = fn + 1; e_rd = fn * 2 * ws + 2 * NW; end
      if (fo == 1) e_er++;
    end
    @(negedge clk); env_clear = 1; fail_n = fn; stuck = sa; fault_on = fo; supply_ok = sup;
    @(negedge clk); env_clear = 0;
    start = 1; @(negedge clk); start = 0;
    check(busy == 1'b1, {tag, " R1 busy after start"}, busy, 1);
    if (extra) begin
      repeat (20) @(negedge clk);
      start = 1; @(negedge clk); start = 0;
    end
    w = 0;
    while (n_done == 0 && w < 20000) begin @(negedge clk); w++; end
    check(w < 20000, {tag, " watchdog"}, w, 20000);
    check(done == 1'b0, {tag, " R8 done one cycle"}, done, 0);
    repeat (3) @(negedge clk);
    check(n_done == 1, {tag, " R1/R8 done count"}, n_done, 1);
    check(busy == 1'b0, {tag, " R8 idle after exit"}, busy, 0);
    check(result == 2'(e_res), {tag, " R5/R7/R3 result"}, result, e_res);
    check(erase_n == e_er, {tag, " R5/R3 erase count"}, erase_n, e_er);
    check(n_reads == e_rd, {tag, " R7 read count"}, n_reads, e_rd);
    check(pair_bad == 0, {tag, " R4 read pair spacing"}, pair_bad, 0);
    check(busy_rd_bad == 0, {tag, " R2 read while busy"}, busy_rd_bad, 0);
    check(clr_bad == 0, {tag, " R8 write enable cleared"}, clr_bad, 0);
  endtask

  initial begin
    int wd;
    wd = 0;
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0, "R9 reset busy/done", {busy, done}, 0);
    check(ctrl_we == 0 && rd_en == 0, "R9 reset strobes", {ctrl_we, rd_en}, 0);
    rst = 0;
    run_case(0, BASE, 0, 1, 0, "clean R7 R4 R6");
    for (int a = BASE; a <= LIMIT; a++) run_case(1, a, 0, 1, 0, "sweep R5");
    for (int f = 0; f <= MAXA + 1; f++) run_case(f, 5, 0, 1, 0, "attempts R5");
    run_case(0, BASE, 1, 1, 0, "fault retry R3");
    run_case(0, BASE, 1, 0, 0, "fault abort R3");
    run_case(MAXA, BASE, 0, 1, 1, "start while busy R1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule